// File: doc/BRIEF.md
# Coprocessor Restart Timer Controller

This block decides when a small always-on coprocessor runs. While the coprocessor is running, its core hands over stop-type instruction words. The block decodes three of them. A halt parks the program and lets the restart timer bring it back. An end parks the program, switches the timer off and can ask the main processor to wake. A sleep parks the program and picks which of five period registers times the next restart. When the timer runs out, the block emits a one-cycle start pulse and marks the coprocessor as running again.

Five period registers and a timer-enable control are written through a small register write port. A period of zero is treated as one cycle. The wake request stays high until the host acknowledges it. A sleep index outside the five registers falls back to register 0 and sets a sticky error flag.

Top module: `lpc_wake_ctrl`

## Requirements
- R1: After reset, start_pulse, cop_running, timer_armed, wake_req and idx_err are 0, every period register is 0 and the selected period index is 0.
- R2: Instruction decode uses bits [31:28] as the major opcode. 4'hB is halt. 4'h9 is the stop family, whose sub-opcode in bits [27:25] is 3'b000 for end and 3'b001 for sleep. Any other word leaves all state and outputs unchanged.
- R3: A halt accepted while running clears cop_running and keeps timer_armed at 1. The restart then follows after the effective period of the currently selected register.
- R4: An end accepted while running clears cop_running and timer_armed. No start pulse follows until the timer is enabled again through the register port.
- R5: An end whose bit 0 is 1 sets wake_req on the accepting edge. wake_req stays high until host_ack is sampled high. If a set and an acknowledge arrive in the same cycle, the set wins.
- R6: A sleep accepted while running takes its period index from bits [2:0]. That register times the restart, and it stays selected for later halts and timer enables.
- R7: A sleep index of 5, 6 or 7 selects register 0 and sets idx_err. idx_err stays set until reset.
- R8: Let L be the selected period value, or 1 when that value is 0. If the timer is loaded on clock edge E, start_pulse and cop_running both become 1 after edge E+L. start_pulse is high for exactly one cycle.
- R9: A stop instruction presented while cop_running is 0 is ignored. It changes neither the selected index nor idx_err nor the arming.
- R10: A register write to address 0..4 loads that period register. A write to address 5 with data bit 0 set arms the timer while it is stopped and disarmed, loading the timer with the currently selected period (timing as in R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word from the coprocessor core is valid |
| insn_word | input | 32 | Instruction word |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0..4 periods, 5 control) |
| cfg_wdata | input | 16 | Register write data |
| host_ack | input | 1 | Host acknowledges the wake request |
| start_pulse | output | 1 | One-cycle start of the coprocessor program |
| cop_running | output | 1 | Coprocessor is running |
| timer_armed | output | 1 | Restart timer is enabled |
| wake_req | output | 1 | Wake request to the main processor |
| idx_err | output | 1 | Sticky out-of-range sleep index flag |

## Verification
The restart delay is measured in clock edges for sleeps to every period register, including a zero period and out-of-range indices. This separates a wrong index mux, a missing zero-to-one substitution and an off-by-one in the counter. Halt, end with and without the wake bit, and unrelated words show whether the three stop kinds and the sub-opcode are told apart. A stop sent to a parked coprocessor, followed by a timer enable, shows whether ignored instructions leak into the selected period. A reset taken after a period write shows that the period registers are cleared.

// File: rtl/lpc_wake_pkg.sv
package lpc_wake_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned IDX_FLD_W = 3;

  localparam logic [3:0] OP_HALT   = 4'hB;
  localparam logic [3:0] OP_STOP   = 4'h9;
  localparam logic [2:0] SUB_END   = 3'd0;
  localparam logic [2:0] SUB_SLEEP = 3'd1;

  typedef enum logic [1:0] {
    STOP_NONE,
    STOP_HALT,
    STOP_END,
    STOP_SLEEP
  } stop_kind_e;

  typedef struct packed {
    stop_kind_e             kind;
    logic                   wake;
    logic [IDX_FLD_W-1:0]   idx;
  } stop_cmd_t;

  function automatic stop_cmd_t decode_stop(input logic [INSN_W-1:0] w);
    stop_cmd_t c;
    c.kind = STOP_NONE;
    c.wake = w[0];
    c.idx  = w[IDX_FLD_W-1:0];
    if (w[31:28] == OP_HALT) begin
      c.kind = STOP_HALT;
    end else if (w[31:28] == OP_STOP) begin
      if (w[27:25] == SUB_END)        c.kind = STOP_END;
      else if (w[27:25] == SUB_SLEEP) c.kind = STOP_SLEEP;
    end
    return c;
  endfunction

endpackage

// File: rtl/lpc_stop_decode.sv
module lpc_stop_decode
  import lpc_wake_pkg::*;
#(
  parameter int unsigned NTMR = 5,
  parameter int unsigned IDXW = 3
) (
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              running,
  output logic              halt_acc,
  output logic              end_acc,
  output logic              sleep_acc,
  output logic              wake_bit,
  output logic [IDXW-1:0]   sleep_idx,
  output logic              idx_bad
);

  stop_cmd_t cmd;
  logic      take;
  logic      unused_bits;

  assign cmd         = decode_stop(insn_word);
  assign take        = insn_valid && running;
  assign unused_bits = ^insn_word[24:IDX_FLD_W];

  assign halt_acc  = take && (cmd.kind == STOP_HALT);
  assign end_acc   = take && (cmd.kind == STOP_END);
  assign sleep_acc = take && (cmd.kind == STOP_SLEEP);
  assign wake_bit  = cmd.wake;
  assign idx_bad   = int'(cmd.idx) >= int'(NTMR);
  assign sleep_idx = idx_bad ? '0 : cmd.idx[IDXW-1:0];

endmodule

// File: rtl/lpc_period_bank.sv
module lpc_period_bank #(
  parameter int unsigned NTMR   = 5,
  parameter int unsigned PW     = 16,
  parameter int unsigned IDXW   = 3,
  parameter int unsigned CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [PW-1:0]     wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [PW-1:0]     rd_eff
);

  logic [PW-1:0] per_q [NTMR];
  logic [PW-1:0] raw;

  function automatic logic [PW-1:0] eff_period(input logic [PW-1:0] p);
    return (p == '0) ? PW'(1) : p;
  endfunction

  for (genvar k = 0; k < NTMR; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    per_q[k] <= '0;
      else if (wr_en && (wr_addr == CFG_AW'(k)))     per_q[k] <= wr_data;
    end
  end

  always_comb begin
    raw = per_q[0];
    for (int k = 0; k < int'(NTMR); k++) begin
      if (rd_idx == IDXW'(k)) raw = per_q[k];
    end
  end

  assign rd_eff = eff_period(raw);

endmodule

// File: rtl/lpc_restart_timer.sv
module lpc_restart_timer #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          count_en,
  output logic          expire
);

  logic [PW-1:0] cnt_q;

  assign expire = count_en && (cnt_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load)                       cnt_q <= load_val;
    else if (count_en && cnt_q > PW'(1)) cnt_q <= cnt_q - PW'(1);
  end

endmodule

// File: rtl/lpc_wake_ctrl.sv
module lpc_wake_ctrl
  import lpc_wake_pkg::*;
#(
  parameter int unsigned NTMR   = 5,
  parameter int unsigned PW     = 16,
  parameter int unsigned CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [PW-1:0]     cfg_wdata,
  input  logic              host_ack,
  output logic              start_pulse,
  output logic              cop_running,
  output logic              timer_armed,
  output logic              wake_req,
  output logic              idx_err
);

  localparam int unsigned IDXW      = (NTMR > 1) ? $clog2(NTMR) : 1;
  localparam int unsigned CTRL_ADDR = NTMR;

  logic            running_q, armed_q, wake_q, err_q, pulse_q;
  logic [IDXW-1:0] sel_q;

  logic            halt_acc, end_acc, sleep_acc, wake_bit, idx_bad;
  logic [IDXW-1:0] dec_idx, rd_idx;
  logic [PW-1:0]   rd_eff;
  logic            stop_acc, en_wr, arm_acc, expire, tmr_load, count_en;

  lpc_stop_decode #(.NTMR(NTMR), .IDXW(IDXW)) u_dec (
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .running    (running_q),
    .halt_acc   (halt_acc),
    .end_acc    (end_acc),
    .sleep_acc  (sleep_acc),
    .wake_bit   (wake_bit),
    .sleep_idx  (dec_idx),
    .idx_bad    (idx_bad)
  );

  assign rd_idx = sleep_acc ? dec_idx : sel_q;

  lpc_period_bank #(.NTMR(NTMR), .PW(PW), .IDXW(IDXW), .CFG_AW(CFG_AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_idx  (rd_idx),
    .rd_eff  (rd_eff)
  );

  assign stop_acc = halt_acc || end_acc || sleep_acc;
  assign en_wr    = cfg_we && (cfg_addr == CFG_AW'(CTRL_ADDR)) && cfg_wdata[0];
  assign arm_acc  = en_wr && !running_q && !armed_q;
  assign count_en = armed_q && !running_q;
  assign tmr_load = halt_acc || sleep_acc || arm_acc || expire;

  lpc_restart_timer #(.PW(PW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (rd_eff),
    .count_en (count_en),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      sel_q     <= '0;
      wake_q    <= 1'b0;
      err_q     <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= expire;
      if (stop_acc)    running_q <= 1'b0;
      else if (expire) running_q <= 1'b1;
      if (end_acc)      armed_q <= 1'b0;
      else if (arm_acc) armed_q <= 1'b1;
      if (sleep_acc) sel_q <= dec_idx;
      if (sleep_acc && idx_bad) err_q <= 1'b1;
      if (end_acc && wake_bit) wake_q <= 1'b1;
      else if (host_ack)       wake_q <= 1'b0;
    end
  end

  assign start_pulse = pulse_q;
  assign cop_running = running_q;
  assign timer_armed = armed_q;
  assign wake_req    = wake_q;
  assign idx_err     = err_q;

endmodule

// File: rtl/lpc_wake_chk.sv
module lpc_wake_chk #(
  parameter int unsigned IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic            host_ack,
  input logic            start_pulse,
  input logic            cop_running,
  input logic            timer_armed,
  input logic            wake_req,
  input logic            idx_err,
  input logic            end_acc,
  input logic            wake_bit,
  input logic [IDXW-1:0] sel_q
);

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r8_pulse_with_run: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> cop_running);

  a_r8_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(timer_armed));

  a_r3_running_armed: assert property (@(posedge clk) disable iff (!rst_n)
    cop_running |-> timer_armed);

  a_r4_end_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    end_acc |=> (!timer_armed && !cop_running));

  a_r5_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    (end_acc && wake_bit) |=> wake_req);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !(end_acc && wake_bit)) |=> !wake_req);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(idx_err));

  a_r9_ignore_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !cop_running) |=> ($stable(sel_q) && $stable(idx_err)));

endmodule

bind lpc_wake_ctrl lpc_wake_chk #(.IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_valid  (insn_valid),
  .host_ack    (host_ack),
  .start_pulse (start_pulse),
  .cop_running (cop_running),
  .timer_armed (timer_armed),
  .wake_req    (wake_req),
  .idx_err     (idx_err),
  .end_acc     (end_acc),
  .wake_bit    (wake_bit),
  .sel_q       (sel_q)
);

// File: tb/lpc_wake_ctrl_tb.sv
module lpc_wake_ctrl_tb;

  localparam int PW = 16;
  localparam logic [31:0] W_HALT  = 32'hB000_0000;
  localparam logic [31:0] W_END   = 32'h9000_0000;
  localparam logic [31:0] W_SLEEP = 32'h9200_0000;

  // row: sleep index [3:1], expected idx_err after the row [0]
  localparam logic [3:0] VEC [8] = '{
    {3'd1, 1'b0}, {3'd4, 1'b0}, {3'd2, 1'b0}, {3'd0, 1'b0},
    {3'd3, 1'b0}, {3'd6, 1'b1}, {3'd4, 1'b1}, {3'd7, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic        host_ack = 1'b0;
  logic        start_pulse, cop_running, timer_armed, wake_req, idx_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int pv [5] = '{0, 3, 5, 2, 7};

  always #4 clk = ~clk;

  lpc_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .host_ack(host_ack),
    .start_pulse(start_pulse), .cop_running(cop_running), .timer_armed(timer_armed),
    .wake_req(wake_req), .idx_err(idx_err)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [2:0] a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = PW'(d);
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); insn_valid = 1'b1; insn_word = w;
    @(posedge clk); #1 insn_valid = 1'b0; insn_word = '0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!start_pulse && n < 60);
  endtask

  task automatic count_pulses(input int cyc, output int seen);
    seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (start_pulse) seen++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n, seen, sel;
    do_reset();
    // R1 reset state
    check("R1", "start_pulse", int'(start_pulse), 0);
    check("R1", "cop_running", int'(cop_running), 0);
    check("R1", "timer_armed", int'(timer_armed), 0);
    check("R1", "wake_req",    int'(wake_req), 0);
    check("R1", "idx_err",     int'(idx_err), 0);

    // R1 period registers cleared by reset
    cfg_write(3'd1, 9);
    do_reset();
    cfg_write(3'd5, 1);
    wait_pulse(n);
    check("R10", "enable restart cycles", n, 1);
    check("R8", "running with pulse", int'(cop_running), 1);
    @(negedge clk);
    check("R8", "pulse one cycle", int'(start_pulse), 0);
    issue(W_SLEEP | 32'd1);
    wait_pulse(n);
    check("R1", "cleared period cycles", n, 1);

    for (int k = 0; k < 5; k++) cfg_write(3'(k), pv[k]);

    // R6 R7 R8 table of sleeps
    for (int r = 0; r < 8; r++) begin
      sel = (int'(VEC[r][3:1]) < 5) ? int'(VEC[r][3:1]) : 0;
      issue(W_SLEEP | 32'(VEC[r][3:1]));
      wait_pulse(n);
      check("R6", $sformatf("sleep idx %0d cycles", VEC[r][3:1]), n, eff(pv[sel]));
      check("R7", "idx_err", int'(idx_err), int'(VEC[r][0]));
      check("R8", "running after pulse", int'(cop_running), 1);
    end

    // R3 halt keeps timer and current selection
    issue(W_SLEEP | 32'd2);
    wait_pulse(n);
    issue(W_HALT);
    check("R3", "armed after halt", int'(timer_armed), 1);
    check("R3", "stopped after halt", int'(cop_running), 0);
    wait_pulse(n);
    check("R3", "halt restart cycles", n - 1 + 1, eff(pv[2]));

    // R2 unrelated words ignored
    issue(32'h1234_5678);
    issue(32'h9400_0003);
    count_pulses(10, seen);
    check("R2", "pulses after unrelated words", seen, 0);
    check("R2", "still running", int'(cop_running), 1);

    // R4 end without wake
    issue(W_END);
    check("R4", "running after end", int'(cop_running), 0);
    check("R4", "armed after end", int'(timer_armed), 0);
    check("R5", "no wake for bit0=0", int'(wake_req), 0);
    count_pulses(20, seen);
    check("R4", "pulses after end", seen, 0);

    // R9 stop while stopped ignored; selection stays 2
    issue(W_SLEEP | 32'd4);
    issue(W_HALT);
    check("R9", "armed unchanged", int'(timer_armed), 0);
    cfg_write(3'd5, 1);
    wait_pulse(n);
    check("R9", "restart uses old selection", n, eff(pv[2]));

    // R5 end with wake
    issue(W_END | 32'd1);
    check("R5", "wake set", int'(wake_req), 1);
    repeat (3) @(negedge clk);
    check("R5", "wake held", int'(wake_req), 1);
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    check("R5", "wake cleared by ack", int'(wake_req), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule